// File: doc/BRIEF.md
# Shadow-Banked Integer Register File

This block is a 32-entry, 64-bit integer register file with two combinational read ports and one write port. Eight register numbers (8 through 14, and 25) each have a second physical copy in a shadow bank. A one-bit handler-mode flag decides which copy those numbers reach. While the flag is set, privileged handler code can use those eight registers freely. The interrupted program's values in the normal bank stay untouched, so the handler needs no save or restore sequence.

A single-cycle pulse on the entry input sets the flag. A pulse on the return input clears it. The flag is a register, so a change of mode applies to accesses from the next cycle on. The shadow bank keeps its contents between handler intervals, which supports repeated or nested handler entry. Register 31 is hard-wired to zero. A read of the register being written in the same cycle is forwarded from the write data.

Top module: `shadowRegFile`

## Requirements
- R1: After reset, every register number in both banks reads as zero and `handlerMode` is 0.
- R2: Register 31 always reads zero on both ports, and a write to it has no effect, in either mode.
- R3: Register numbers other than 8–14 and 25 use one common storage location whatever the mode, so a value written in one mode can be read back in the other.
- R4: While `handlerMode` is 1, reads and writes of register numbers 8, 9, 10, 11, 12, 13, 14 and 25 use the shadow bank. While it is 0, they use the normal bank.
- R5: A cycle with `enterPulse`=1 makes `handlerMode` 1 on the next cycle, even when `returnPulse` is also 1. A cycle with only `returnPulse`=1 makes it 0. With neither pulse it holds.
- R6: Accesses made in the same cycle as an entry or return pulse use the bank of the mode in force before that pulse.
- R7: The normal-bank values of registers 8–14 and 25 are the same after a handler interval as they were before it, even when handler code writes all of those numbers.
- R8: Shadow-bank contents written in one handler interval are read back unchanged in the next handler interval.
- R9: When the write port writes a nonzero-numbered register and a read port addresses that register in the same cycle, the read port returns the write data.
- R10: The two read ports are independent: each returns the value for its own address in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| enterPulse | input | 1 | Handler-entry event, one cycle |
| returnPulse | input | 1 | Handler-return event, one cycle |
| wrEn | input | 1 | Write enable |
| wrAddr | input | 5 | Write register number |
| wrData | input | 64 | Write data |
| rdAddrA | input | 5 | Read port A register number |
| rdDataA | output | 64 | Read port A data, combinational |
| rdAddrB | input | 5 | Read port B register number |
| rdDataB | output | 64 | Read port B data, combinational |
| handlerMode | output | 1 | Current handler-mode flag |

## Verification
The hardest cases to reach are those where the two banks disagree at a mode boundary. These need a shadowed register written in handler mode in the same cycle as the return pulse, and a full handler interval that overwrites every shadowed number. The bench first fills all 32 registers with distinct arithmetic patterns in normal mode, then fills them again with different patterns in handler mode. It places writes on the exact cycles of the entry and return pulses. After that it sweeps every register on both ports in each mode. A combined entry-and-return cycle starts the second handler interval, which shows both that entry has priority and that the shadow values persisted.

// File: rtl/shadow_rf_pkg.sv
`timescale 1ns/1ps
package shadow_rf_pkg;

  // Strobes from the control block to the datapath.
  typedef struct packed {
    logic wrCommon;    // write lands in the common/normal bank
    logic wrShadow;    // write lands in the shadow bank
    logic selShadowA;  // port A reads the shadow bank
    logic selShadowB;  // port B reads the shadow bank
    logic zeroA;       // port A addresses the zero register
    logic zeroB;       // port B addresses the zero register
    logic bypassA;     // port A forwards write data
    logic bypassB;     // port B forwards write data
  } rfStrobes_t;

  // Shadow slot of a register number: count of shadowed numbers below it.
  function automatic int unsigned shadowSlot(input logic [63:0] mask,
                                             input int unsigned regNum);
    int unsigned cnt;
    cnt = 0;
    for (int unsigned i = 0; i < 64; i++) begin
      if (i < regNum && mask[i]) cnt++;
    end
    return cnt;
  endfunction

  // Register number held by a given shadow slot.
  function automatic int unsigned slotRegNum(input logic [63:0] mask,
                                             input int unsigned slot);
    int unsigned cnt;
    int unsigned found;
    cnt = 0;
    found = 0;
    for (int unsigned i = 0; i < 64; i++) begin
      if (mask[i]) begin
        if (cnt == slot) found = i;
        cnt++;
      end
    end
    return found;
  endfunction

endpackage

// File: rtl/shadow_rf_ctrl.sv
`timescale 1ns/1ps
module shadow_rf_ctrl
  import shadow_rf_pkg::*;
#(
  parameter int unsigned NUM_REGS    = 32,
  parameter logic [NUM_REGS-1:0] SHADOW_MASK = 32'h0200_7F00,
  parameter int unsigned ZERO_REG    = 31,
  localparam int unsigned ADDR_W     = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enterPulse,
  input  logic              returnPulse,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [ADDR_W-1:0] rdAddrA,
  input  logic [ADDR_W-1:0] rdAddrB,
  output logic              handlerMode,
  output rfStrobes_t        strobes
);

  logic modeQ;
  logic wrValid;
  logic wrIsShadowed;

  // Mode flag: entry has priority over return.
  always_ff @(posedge clk) begin
    if (!rstN)            modeQ <= 1'b0;
    else if (enterPulse)  modeQ <= 1'b1;
    else if (returnPulse) modeQ <= 1'b0;
  end

  assign handlerMode = modeQ;

  always_comb begin
    wrValid      = wrEn && (wrAddr != ADDR_W'(ZERO_REG));
    wrIsShadowed = SHADOW_MASK[wrAddr];

    strobes.wrShadow   = wrValid && modeQ && wrIsShadowed;
    strobes.wrCommon   = wrValid && !(modeQ && wrIsShadowed);
    strobes.selShadowA = modeQ && SHADOW_MASK[rdAddrA];
    strobes.selShadowB = modeQ && SHADOW_MASK[rdAddrB];
    strobes.zeroA      = (rdAddrA == ADDR_W'(ZERO_REG));
    strobes.zeroB      = (rdAddrB == ADDR_W'(ZERO_REG));
    strobes.bypassA    = wrValid && (wrAddr == rdAddrA);
    strobes.bypassB    = wrValid && (wrAddr == rdAddrB);
  end

endmodule

// File: rtl/shadow_rf_dp.sv
`timescale 1ns/1ps
module shadow_rf_dp
  import shadow_rf_pkg::*;
#(
  parameter int unsigned DATA_W      = 64,
  parameter int unsigned NUM_REGS    = 32,
  parameter logic [NUM_REGS-1:0] SHADOW_MASK = 32'h0200_7F00,
  localparam int unsigned ADDR_W     = $clog2(NUM_REGS),
  localparam int unsigned SHADOW_CNT = $countones(SHADOW_MASK),
  localparam int unsigned SLOT_W     = (SHADOW_CNT > 1) ? $clog2(SHADOW_CNT) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  rfStrobes_t        strobes,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddrA,
  input  logic [ADDR_W-1:0] rdAddrB,
  output logic [DATA_W-1:0] rdDataA,
  output logic [DATA_W-1:0] rdDataB
);

  logic [DATA_W-1:0] commonBank [NUM_REGS];
  logic [DATA_W-1:0] shadowBank [SHADOW_CNT];
  logic [SLOT_W-1:0] slotA;
  logic [SLOT_W-1:0] slotB;
  logic [DATA_W-1:0] rawA;
  logic [DATA_W-1:0] rawB;

  // Normal/common bank: one flop row per register number.
  for (genvar g = 0; g < NUM_REGS; g++) begin : gCommon
    always_ff @(posedge clk) begin
      if (!rstN)
        commonBank[g] <= '0;
      else if (strobes.wrCommon && wrAddr == ADDR_W'(g))
        commonBank[g] <= wrData;
    end
  end

  // Shadow bank: one row per shadowed register number.
  for (genvar s = 0; s < SHADOW_CNT; s++) begin : gShadow
    localparam int unsigned REG_NUM = slotRegNum(64'(SHADOW_MASK), s);
    always_ff @(posedge clk) begin
      if (!rstN)
        shadowBank[s] <= '0;
      else if (strobes.wrShadow && wrAddr == ADDR_W'(REG_NUM))
        shadowBank[s] <= wrData;
    end
  end

  always_comb begin
    slotA = SLOT_W'(shadowSlot(64'(SHADOW_MASK), int'(rdAddrA)));
    slotB = SLOT_W'(shadowSlot(64'(SHADOW_MASK), int'(rdAddrB)));
    rawA  = strobes.selShadowA ? shadowBank[slotA] : commonBank[rdAddrA];
    rawB  = strobes.selShadowB ? shadowBank[slotB] : commonBank[rdAddrB];

    if (strobes.zeroA)        rdDataA = '0;
    else if (strobes.bypassA) rdDataA = wrData;
    else                      rdDataA = rawA;

    if (strobes.zeroB)        rdDataB = '0;
    else if (strobes.bypassB) rdDataB = wrData;
    else                      rdDataB = rawB;
  end

endmodule

// File: rtl/shadowRegFile.sv
`timescale 1ns/1ps
module shadowRegFile
  import shadow_rf_pkg::*;
#(
  parameter int unsigned DATA_W   = 64,
  parameter int unsigned NUM_REGS = 32,
  parameter logic [NUM_REGS-1:0] SHADOW_MASK = 32'h0200_7F00,
  parameter int unsigned ZERO_REG = 31,
  localparam int unsigned ADDR_W  = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enterPulse,
  input  logic              returnPulse,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddrA,
  output logic [DATA_W-1:0] rdDataA,
  input  logic [ADDR_W-1:0] rdAddrB,
  output logic [DATA_W-1:0] rdDataB,
  output logic              handlerMode
);

  rfStrobes_t strobes;

  shadow_rf_ctrl #(
    .NUM_REGS(NUM_REGS), .SHADOW_MASK(SHADOW_MASK), .ZERO_REG(ZERO_REG)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .enterPulse(enterPulse), .returnPulse(returnPulse),
    .wrEn(wrEn), .wrAddr(wrAddr), .rdAddrA(rdAddrA), .rdAddrB(rdAddrB),
    .handlerMode(handlerMode), .strobes(strobes)
  );

  shadow_rf_dp #(
    .DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .SHADOW_MASK(SHADOW_MASK)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddrA(rdAddrA), .rdAddrB(rdAddrB), .rdDataA(rdDataA), .rdDataB(rdDataB)
  );

endmodule

// File: rtl/shadow_rf_chk.sv
`timescale 1ns/1ps
module shadow_rf_chk #(
  parameter int unsigned DATA_W   = 64,
  parameter int unsigned NUM_REGS = 32,
  parameter int unsigned ZERO_REG = 31,
  localparam int unsigned ADDR_W  = $clog2(NUM_REGS)
) (
  input logic              clk,
  input logic              rstN,
  input logic              enterPulse,
  input logic              returnPulse,
  input logic              wrEn,
  input logic [ADDR_W-1:0] wrAddr,
  input logic [DATA_W-1:0] wrData,
  input logic [ADDR_W-1:0] rdAddrA,
  input logic [DATA_W-1:0] rdDataA,
  input logic [ADDR_W-1:0] rdAddrB,
  input logic [DATA_W-1:0] rdDataB,
  input logic              handlerMode
);

  AST_ZERO_REG_A: assert property (@(posedge clk) disable iff (!rstN)
    (rdAddrA == ADDR_W'(ZERO_REG)) |-> (rdDataA == '0));  // R2
  AST_ZERO_REG_B: assert property (@(posedge clk) disable iff (!rstN)
    (rdAddrB == ADDR_W'(ZERO_REG)) |-> (rdDataB == '0));  // R2
  AST_ENTRY_SETS: assert property (@(posedge clk) disable iff (!rstN)
    enterPulse |=> handlerMode);  // R5
  AST_RETURN_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (returnPulse && !enterPulse) |=> !handlerMode);  // R5
  AST_MODE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (!enterPulse && !returnPulse) |=> $stable(handlerMode));  // R5
  AST_BYPASS_A: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == rdAddrA && wrAddr != ADDR_W'(ZERO_REG)) |-> (rdDataA == wrData));  // R9
  AST_BYPASS_B: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == rdAddrB && wrAddr != ADDR_W'(ZERO_REG)) |-> (rdDataB == wrData));  // R9

endmodule

bind shadowRegFile shadow_rf_chk #(
  .DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .ZERO_REG(ZERO_REG)
) u_chk (
  .clk(clk), .rstN(rstN), .enterPulse(enterPulse), .returnPulse(returnPulse),
  .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData), .rdAddrA(rdAddrA),
  .rdDataA(rdDataA), .rdAddrB(rdAddrB), .rdDataB(rdDataB), .handlerMode(handlerMode)
);

// File: tb/shadowRegFile_tb.sv
`timescale 1ns/1ps
module shadowRegFile_tb;

  localparam logic [31:0] SH_MASK = 32'h0200_7F00;  // numbers 8..14 and 25

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        enterPulse = 1'b0, returnPulse = 1'b0, wrEn = 1'b0;
  logic [4:0]  wrAddr = '0, rdAddrA = '0, rdAddrB = '0;
  logic [63:0] wrData = '0;
  logic [63:0] rdDataA, rdDataB;
  logic        handlerMode;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [63:0] normMdl [32];
  logic [63:0] shadMdl [32];
  logic        modeMdl = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  shadowRegFile u_dut (
    .clk(clk), .rstN(rstN), .enterPulse(enterPulse), .returnPulse(returnPulse),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData), .rdAddrA(rdAddrA),
    .rdDataA(rdDataA), .rdAddrB(rdAddrB), .rdDataB(rdDataB), .handlerMode(handlerMode)
  );

  function automatic logic [63:0] pat(input int r, input int k);
    return (64'h9E37_79B9_7F4A_7C15 * 64'(r + 1)) ^ (64'(k) << 56) ^ 64'(k * 4099);
  endfunction

  function automatic logic [63:0] expRead(input logic [4:0] r);
    if (r == 5'd31) return '0;
    if (wrEn && wrAddr == r) return wrData;
    if (modeMdl && SH_MASK[r]) return shadMdl[r];
    return normMdl[r];
  endfunction

  task automatic chk64(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // One cycle: drive after negedge, check before posedge, update model at posedge.
  task automatic cyc(input string tag, input logic we, input int wa, input logic [63:0] wd,
                     input int ra, input int rb, input logic ent, input logic ret);
    wrEn = we; wrAddr = 5'(wa); wrData = wd;
    rdAddrA = 5'(ra); rdAddrB = 5'(rb);
    enterPulse = ent; returnPulse = ret;
    #1;
    chk64(tag, $sformatf("portA reg %0d", ra), rdDataA, expRead(5'(ra)));
    chk64(tag, $sformatf("portB reg %0d", rb), rdDataB, expRead(5'(rb)));
    chk64(tag, "handlerMode", 64'(handlerMode), 64'(modeMdl));
    @(posedge clk);
    if (we && wa != 31) begin
      if (modeMdl && SH_MASK[wa]) shadMdl[wa] = wd;
      else normMdl[wa] = wd;
    end
    if (ent) modeMdl = 1'b1;
    else if (ret) modeMdl = 1'b0;
    @(negedge clk);
  endtask

  task automatic readSweep(input string tag);
    for (int r = 0; r < 32; r++) cyc(tag, 0, 0, '0, r, (r * 7 + 3) % 32, 0, 0);
  endtask

  initial begin
    for (int i = 0; i < 32; i++) begin normMdl[i] = '0; shadMdl[i] = '0; end
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: everything zero after reset
    readSweep("R1");
    // R9: write every register in normal mode, reading it back on port A
    for (int r = 0; r < 32; r++) cyc("R9", 1, r, pat(r, 1), r, (r + 31) % 32, 0, 0);
    // R3 / R10: independent read sweep in normal mode
    readSweep("R10");
    // R6: entry cycle writes reg 8 into the normal bank
    cyc("R6", 1, 8, pat(8, 5), 8, 25, 1, 0);
    // R4: shadowed numbers now show the zeroed shadow bank; R3 for the rest
    readSweep("R4");
    // R9: overwrite everything while in handler mode
    for (int r = 0; r < 32; r++) cyc("R9", 1, r, pat(r, 2), r, 31 - r, 0, 0);
    readSweep("R3");
    // R2: write to the zero register in handler mode has no effect
    cyc("R2", 1, 31, 64'hFFFF_FFFF_FFFF_FFFF, 31, 31, 0, 0);
    cyc("R2", 0, 0, '0, 31, 0, 0, 0);
    // R6: return cycle writes reg 10 into the shadow bank
    cyc("R6", 1, 10, pat(10, 3), 10, 9, 0, 1);
    // R7: normal-bank values of shadowed registers preserved
    readSweep("R7");
    // R2 in normal mode
    cyc("R2", 1, 31, 64'h1234_5678_9ABC_DEF0, 31, 8, 0, 0);
    cyc("R2", 0, 0, '0, 31, 31, 0, 0);
    // R5: simultaneous entry and return, entry wins
    cyc("R5", 0, 0, '0, 12, 13, 1, 1);
    // R8: shadow contents persisted into the second handler interval
    readSweep("R8");
    // R5: return alone clears the mode
    cyc("R5", 0, 0, '0, 25, 14, 0, 1);
    cyc("R5", 0, 0, '0, 25, 14, 0, 0);
    readSweep("R7");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule